// File: doc/BRIEF.md
# USB Host Controller Register and Buffer Space

This block is the byte-wide, RAM-like space that a microprocessor sees on a dual-mode USB controller. An 8-bit address selects either a control or status register, or a byte of packet memory. A mode pin picks the layout. In host layout the lowest sixteen addresses are registers: two identical transfer channels, a few common registers, an interrupt status port and a hardware revision code. In peripheral layout the lowest 64 bytes are peripheral register bytes, and packet memory follows them. In this block every byte in peripheral layout is plain storage.

Several host addresses mean one thing on a write and another on a read. A write to a channel's PID/endpoint slot stores the value for the transfer engine, while a read of that slot returns the channel's USB status. The device-address slot works the same way and reads back the transfer count. The SOF-low slot reads back the revision code. A reset clears only a chosen subset of registers, and for the channel control registers it clears only bit 0. Any host write to address 0Fh sets a sticky full-features flag, which is brought out on a pin.

The interface is plain strobes rather than a stream. An access is accepted on every cycle in which it is presented, so there is no back-pressure. Read data is registered and is marked by a one-cycle valid pulse.

Top module: `usbh_regspace`

## Requirements
- R1: In host mode (`periph_mode`=0), a write to 00h, 01h, 02h, 05h, 06h, 07h, 08h, 09h, 0Ah or 0Fh is returned unchanged by a later read of the same address.
- R2: In host mode, a write to 03h (channel A) or 0Bh (channel B) drives that channel's `*_pid_ep` output. A read of the same address returns that channel's `*_usb_status` input.
- R3: In host mode, a write to 04h or 0Ch drives that channel's `*_dev_addr` output. A read of the same address returns that channel's `*_xfer_cnt` input.
- R4: In host mode, a write to 0Eh drives `sof_low`. A read of 0Eh returns the `HW_REV` parameter.
- R5: In host mode, a read of 0Dh returns the `irq_status` input. A write to 0Dh changes no register.
- R6: `full_feat` is 0 after reset. Any host-mode write to 0Fh sets it, whatever the data. Once set, it stays set until reset.
- R7: Reset clears bit 0 of the registers at 00h and 08h, clears all of 05h and 07h, and clears `sof_low`. The other bits of 00h and 08h, and the registers 01h, 02h, 06h, 09h, 0Ah and 0Fh, keep their contents through a reset.
- R8: In host mode, addresses 10h through FFh behave as ordinary read/write memory.
- R9: In peripheral mode, every address from 00h to FFh reads back the byte last written there. Such writes change no host register and do not set `full_feat`.
- R10: A write takes effect only in a cycle with `cs`=1, `wr`=1 and `rd`=0. A cycle with `rd` and `wr` both high does nothing: it performs no write and raises no `rd_valid`.
- R11: `rd_valid` is 1 in the cycle after a cycle with `cs`=1, `rd`=1 and `wr`=0, and 0 in every other cycle. `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_mode | input | 1 | 0 selects the host layout, 1 the peripheral layout |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 8 | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Pulses high one cycle after an accepted read |
| cha_usb_status | input | 8 | Channel A USB status, driven by the transfer engine |
| cha_xfer_cnt | input | 8 | Channel A transfer count |
| chb_usb_status | input | 8 | Channel B USB status |
| chb_xfer_cnt | input | 8 | Channel B transfer count |
| irq_status | input | 8 | Interrupt status bits |
| cha_pid_ep | output | 8 | Channel A stored PID/endpoint |
| cha_dev_addr | output | 8 | Channel A stored device address |
| chb_pid_ep | output | 8 | Channel B stored PID/endpoint |
| chb_dev_addr | output | 8 | Channel B stored device address |
| sof_low | output | 8 | Stored SOF counter low byte |
| full_feat | output | 1 | Sticky full-features flag |

## Verification
The bench keeps the 8-bit address, the 8-bit data width and the sixteen-entry host register window at their defaults. With these values the full 256-byte map, both edges of the buffer, and the boundary between the peripheral register bytes and packet memory can all be reached. It overrides `HW_REV` with A5h, a value that no reset or stored byte can mimic, so a read of 0Eh shows whether the revision path or the stored SOF byte was selected. It drives distinct values on the status inputs for the two channels, so a channel swap shows up on the read side.

// File: rtl/usbh_regspace_pkg.sv
package usbh_regspace_pkg;
  // host-layout offsets within a channel set
  localparam logic [2:0] CH_CTRL = 3'd0;
  localparam logic [2:0] CH_BASE = 3'd1;
  localparam logic [2:0] CH_LEN  = 3'd2;
  localparam logic [2:0] CH_PID  = 3'd3;
  localparam logic [2:0] CH_DEV  = 3'd4;
  // host-layout common register addresses (low nibble)
  localparam logic [3:0] RG_CTRL1 = 4'h5;
  localparam logic [3:0] RG_IE    = 4'h6;
  localparam logic [3:0] RG_AUX   = 4'h7;
  localparam logic [3:0] RG_IRQ   = 4'hD;
  localparam logic [3:0] RG_SOFLO = 4'hE;
  localparam logic [3:0] RG_SOFHI = 4'hF;
endpackage

// File: rtl/usbh_chan_regs.sv
module usbh_chan_regs
  import usbh_regspace_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] count_in,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] pid_ep,
  output logic [DATA_W-1:0] dev_addr
);
  logic              ctrl_lsb;
  logic [DATA_W-1:1] ctrl_hi;
  logic [DATA_W-1:0] base_q, len_q;

  // only bit 0 of the control register is reset
  always_ff @(posedge clk) begin
    if (!rst_n)                           ctrl_lsb <= 1'b0;
    else if (wr_en && ofs == CH_CTRL)     ctrl_lsb <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (ofs)
        CH_CTRL: ctrl_hi  <= wdata[DATA_W-1:1];
        CH_BASE: base_q   <= wdata;
        CH_LEN:  len_q    <= wdata;
        CH_PID:  pid_ep   <= wdata;
        CH_DEV:  dev_addr <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      CH_CTRL: rd_val = {ctrl_hi, ctrl_lsb};
      CH_BASE: rd_val = base_q;
      CH_LEN:  rd_val = len_q;
      CH_PID:  rd_val = status_in;
      CH_DEV:  rd_val = count_in;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/usbh_common_regs.sv
module usbh_common_regs
  import usbh_regspace_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  HW_REV = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] irq_in,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] sof_low,
  output logic              full_feat
);
  logic [DATA_W-1:0] ctrl1_q, aux_q, ie_q, sofhi_q;

  // registers cleared by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl1_q   <= '0;
      aux_q     <= '0;
      sof_low   <= '0;
      full_feat <= 1'b0;
    end else if (wr_en) begin
      case (ofs)
        RG_CTRL1: ctrl1_q <= wdata;
        RG_AUX:   aux_q   <= wdata;
        RG_SOFLO: sof_low <= wdata;
        RG_SOFHI: full_feat <= 1'b1;
        default: ;
      endcase
    end
  end

  // registers that keep their contents through reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (ofs == RG_IE)    ie_q    <= wdata;
      if (ofs == RG_SOFHI) sofhi_q <= wdata;
    end
  end

  always_comb begin
    case (ofs)
      RG_CTRL1: rd_val = ctrl1_q;
      RG_IE:    rd_val = ie_q;
      RG_AUX:   rd_val = aux_q;
      RG_IRQ:   rd_val = irq_in;
      RG_SOFLO: rd_val = DATA_W'(HW_REV);
      RG_SOFHI: rd_val = sofhi_q;
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/usbh_buf_mem.sv
module usbh_buf_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/usbh_regspace.sv
module usbh_regspace #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         HOST_REGS = 16,
  parameter logic [7:0] HW_REV    = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_mode,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [DATA_W-1:0] cha_usb_status,
  input  logic [DATA_W-1:0] cha_xfer_cnt,
  input  logic [DATA_W-1:0] chb_usb_status,
  input  logic [DATA_W-1:0] chb_xfer_cnt,
  input  logic [DATA_W-1:0] irq_status,
  output logic [DATA_W-1:0] cha_pid_ep,
  output logic [DATA_W-1:0] cha_dev_addr,
  output logic [DATA_W-1:0] chb_pid_ep,
  output logic [DATA_W-1:0] chb_dev_addr,
  output logic [DATA_W-1:0] sof_low,
  output logic              full_feat
);
  localparam int               N_CH     = 2;
  localparam logic [ADDR_W-1:0] HOST_LIM = ADDR_W'(HOST_REGS);

  logic acc_wr, acc_rd, host_reg, ch_hit;
  logic [DATA_W-1:0] ch_rd   [N_CH];
  logic [DATA_W-1:0] ch_stat [N_CH];
  logic [DATA_W-1:0] ch_cnt  [N_CH];
  logic [DATA_W-1:0] ch_pid  [N_CH];
  logic [DATA_W-1:0] ch_dev  [N_CH];
  logic [DATA_W-1:0] cm_rd, mem_rd, rd_mux;

  assign acc_wr   = cs && wr && !rd;
  assign acc_rd   = cs && rd && !wr;
  assign host_reg = !periph_mode && (addr < HOST_LIM);
  // channel slots: offsets 0..4 of each half of the host window
  assign ch_hit   = addr[2:0] <= 3'd4;

  assign ch_stat[0] = cha_usb_status;
  assign ch_stat[1] = chb_usb_status;
  assign ch_cnt[0]  = cha_xfer_cnt;
  assign ch_cnt[1]  = chb_xfer_cnt;
  assign cha_pid_ep   = ch_pid[0];
  assign cha_dev_addr = ch_dev[0];
  assign chb_pid_ep   = ch_pid[1];
  assign chb_dev_addr = ch_dev[1];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    usbh_chan_regs #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc_wr && host_reg && ch_hit && (addr[3] == c[0])),
      .ofs       (addr[2:0]),
      .wdata     (wr_data),
      .status_in (ch_stat[c]),
      .count_in  (ch_cnt[c]),
      .rd_val    (ch_rd[c]),
      .pid_ep    (ch_pid[c]),
      .dev_addr  (ch_dev[c])
    );
  end

  usbh_common_regs #(.DATA_W(DATA_W), .HW_REV(HW_REV)) u_cm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (acc_wr && host_reg && !ch_hit),
    .ofs       (addr[3:0]),
    .wdata     (wr_data),
    .irq_in    (irq_status),
    .rd_val    (cm_rd),
    .sof_low   (sof_low),
    .full_feat (full_feat)
  );

  usbh_buf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (acc_wr && !host_reg),
    .addr  (addr),
    .wdata (wr_data),
    .rdata (mem_rd)
  );

  always_comb begin
    if (!host_reg)   rd_mux = mem_rd;
    else if (ch_hit) rd_mux = ch_rd[addr[3]];
    else             rd_mux = cm_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/usbh_regspace_chk.sv
module usbh_regspace_chk #(
  parameter int         ADDR_W = 8,
  parameter int         DATA_W = 8,
  parameter logic [7:0] HW_REV = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              periph_mode,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] cha_usb_status,
  input logic [DATA_W-1:0] irq_status,
  input logic              full_feat
);
  logic rd_go, hostrd;
  assign rd_go  = cs && rd && !wr;
  assign hostrd = rd_go && !periph_mode;

  a_r11_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
  a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rd_valid);
  a_r10_clash_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && wr) |=> !rd_valid);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full_feat |=> full_feat);
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !rd && !periph_mode && addr == ADDR_W'(8'h0F)) |=> full_feat);
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_feat) |-> $past(cs && wr && !rd && !periph_mode && addr == ADDR_W'(8'h0F)));
  a_r4_revision: assert property (@(posedge clk) disable iff (!rst_n)
    (hostrd && addr == ADDR_W'(8'h0E)) |=> rd_data == DATA_W'(HW_REV));
  a_r2_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hostrd && addr == ADDR_W'(8'h03)) |=> rd_data == $past(cha_usb_status));
  a_r5_irq_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hostrd && addr == ADDR_W'(8'h0D)) |=> rd_data == $past(irq_status));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rd_data));
endmodule

bind usbh_regspace usbh_regspace_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW_REV(HW_REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode), .cs(cs), .rd(rd), .wr(wr),
  .addr(addr), .rd_data(rd_data), .rd_valid(rd_valid), .cha_usb_status(cha_usb_status),
  .irq_status(irq_status), .full_feat(full_feat)
);

// File: tb/usbh_regspace_bench.sv
module usbh_regspace_bench;
  localparam logic [7:0] REV = 8'hA5;
  logic clk = 1'b0;
  logic rst_n = 1'b0, periph_mode = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data, cha_pid_ep, cha_dev_addr, chb_pid_ep, chb_dev_addr, sof_low;
  logic       rd_valid, full_feat;
  logic [7:0] cha_st = 8'h11, cha_cn = 8'h22, chb_st = 8'h33, chb_cn = 8'h44, irq = 8'h5C;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usbh_regspace #(.HW_REV(REV)) u_usbh_regspace (
    .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cha_usb_status(cha_st), .cha_xfer_cnt(cha_cn), .chb_usb_status(chb_st),
    .chb_xfer_cnt(chb_cn), .irq_status(irq), .cha_pid_ep(cha_pid_ep),
    .cha_dev_addr(cha_dev_addr), .chb_pid_ep(chb_pid_ep), .chb_dev_addr(chb_dev_addr),
    .sof_low(sof_low), .full_feat(full_feat)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_byte(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wr_data = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_byte(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
    chk({req, " rd_valid"}, 8'(rd_valid), 8'h01);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk("R11 valid idle after reset", 8'(rd_valid), 8'h00);
    chk("R6 flag clear after reset", 8'(full_feat), 8'h00);
    chk("R7 sof_low cleared", sof_low, 8'h00);
    rd_byte(8'h05, 8'h00, "R7 ctrl1 reset");
    rd_byte(8'h07, 8'h00, "R7 aux reset");
  endtask

  task automatic t_host_regs();
    logic [7:0] a [10] = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0F};
    for (int i = 0; i < 10; i++) wr_byte(a[i], 8'h30 + 8'(i * 7));
    for (int i = 0; i < 10; i++) rd_byte(a[i], 8'h30 + 8'(i * 7), "R1 host reg readback");
  endtask

  task automatic t_split_slots();
    wr_byte(8'h03, 8'h69); wr_byte(8'h0B, 8'h2D);
    wr_byte(8'h04, 8'h05); wr_byte(8'h0C, 8'h7F);
    chk("R2 A pid out", cha_pid_ep, 8'h69);
    chk("R2 B pid out", chb_pid_ep, 8'h2D);
    chk("R3 A dev out", cha_dev_addr, 8'h05);
    chk("R3 B dev out", chb_dev_addr, 8'h7F);
    rd_byte(8'h03, 8'h11, "R2 A status read");
    rd_byte(8'h0B, 8'h33, "R2 B status read");
    rd_byte(8'h04, 8'h22, "R3 A count read");
    rd_byte(8'h0C, 8'h44, "R3 B count read");
    cha_st = 8'hE1; chb_cn = 8'h9A;
    rd_byte(8'h03, 8'hE1, "R2 A status new");
    rd_byte(8'h0C, 8'h9A, "R3 B count new");
    wr_byte(8'h0E, 8'h3C);
    chk("R4 sof_low out", sof_low, 8'h3C);
    rd_byte(8'h0E, REV, "R4 revision read");
    rd_byte(8'h0D, 8'h5C, "R5 irq read");
    wr_byte(8'h0D, 8'h00);
    irq = 8'h81;
    rd_byte(8'h0D, 8'h81, "R5 irq after write");
  endtask

  task automatic t_flag();
    do_reset();
    chk("R6 flag after reset", 8'(full_feat), 8'h00);
    wr_byte(8'h0E, 8'h01);
    chk("R6 flag not set by 0E", 8'(full_feat), 8'h00);
    wr_byte(8'h0F, 8'h00);
    chk("R6 flag set by 0F", 8'(full_feat), 8'h01);
    wr_byte(8'h05, 8'h00); wr_byte(8'h0F, 8'h00);
    chk("R6 flag sticky", 8'(full_feat), 8'h01);
    do_reset();
    chk("R6 flag cleared by reset", 8'(full_feat), 8'h00);
  endtask

  task automatic t_partial_reset();
    wr_byte(8'h00, 8'hFF); wr_byte(8'h08, 8'h81); wr_byte(8'h01, 8'hAA);
    wr_byte(8'h06, 8'h66); wr_byte(8'h05, 8'h77); wr_byte(8'h07, 8'h55);
    wr_byte(8'h0E, 8'h33); wr_byte(8'h0F, 8'hC3); wr_byte(8'h0A, 8'h4B);
    do_reset();
    rd_byte(8'h00, 8'hFE, "R7 ctrlA only bit0");
    rd_byte(8'h08, 8'h80, "R7 ctrlB only bit0");
    rd_byte(8'h01, 8'hAA, "R7 base kept");
    rd_byte(8'h06, 8'h66, "R7 ie kept");
    rd_byte(8'h0A, 8'h4B, "R7 lenB kept");
    rd_byte(8'h0F, 8'hC3, "R7 0F kept");
    rd_byte(8'h05, 8'h00, "R7 ctrl1 cleared");
    rd_byte(8'h07, 8'h00, "R7 aux cleared");
    chk("R7 sof_low cleared", sof_low, 8'h00);
  endtask

  task automatic t_buffer();
    wr_byte(8'h10, 8'hB1); wr_byte(8'h80, 8'h4E); wr_byte(8'hFF, 8'hC7);
    rd_byte(8'h10, 8'hB1, "R8 buffer first");
    rd_byte(8'h80, 8'h4E, "R8 buffer mid");
    rd_byte(8'hFF, 8'hC7, "R8 buffer last");
  endtask

  task automatic t_periph();
    wr_byte(8'h05, 8'h3A);
    periph_mode = 1'b1;
    wr_byte(8'h05, 8'h5A); wr_byte(8'h03, 8'h17); wr_byte(8'h0F, 8'hEE);
    wr_byte(8'h3F, 8'h99); wr_byte(8'h40, 8'h42);
    rd_byte(8'h03, 8'h17, "R9 periph 03 stored");
    rd_byte(8'h05, 8'h5A, "R9 periph 05 stored");
    rd_byte(8'h3F, 8'h99, "R9 periph last reg byte");
    rd_byte(8'h40, 8'h42, "R9 periph first buffer");
    chk("R9 flag untouched", 8'(full_feat), 8'h00);
    chk("R9 pid untouched", cha_pid_ep, 8'h69);
    periph_mode = 1'b0;
    rd_byte(8'h05, 8'h3A, "R9 host ctrl1 untouched");
  endtask

  task automatic t_strobes();
    wr_byte(8'h02, 8'h3C);
    @(negedge clk); cs = 0; wr = 1; addr = 8'h02; wr_data = 8'h00;
    @(negedge clk); wr = 0;
    @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 8'h02; wr_data = 8'hFF;
    @(negedge clk); cs = 0; rd = 0; wr = 0;
    chk("R10 clash raises no valid", 8'(rd_valid), 8'h00);
    rd_byte(8'h02, 8'h3C, "R10 no write without cs or on clash");
    @(negedge clk);
    chk("R11 valid one cycle only", 8'(rd_valid), 8'h00);
    chk("R11 rd_data held", rd_data, 8'h3C);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_host_regs();
        t_split_slots();
        t_flag();
        t_partial_reset();
        t_buffer();
        t_periph();
        t_strobes();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule